// File: doc/BRIEF.md
# Branch and Skip Decision Unit

This unit decides where a small 8-bit core goes next after a control-flow instruction, and how many clocks that instruction occupies. The decoder presents an already-classified operation code together with the current program counter, the two relative offsets, the Z pointer, the status byte, a bit index, the operands of a compare or bit test, and a flag that says whether the instruction after this one is two words long. One clock later the unit returns the next program counter, whether the flow was redirected, the clock count, and a one-shot request to set the global interrupt flag.

Relative jumps and calls add a sign-extended 12-bit offset plus one to the PC. Indirect jumps and calls load the PC from Z. Conditional branches test any one status bit, or the signed N XOR V relation, and add a sign-extended 7-bit offset plus one when taken. Skip tests compare two registers, or test one bit of a register or of a byte read from the low I/O space. A true skip advances the PC past one or two words. Returns only report their clock count, because the stack lies outside this unit.

Top module: `bsu_top`

## Requirements
- R1: While rstN is low, and after reset until the first accepted operation, resValid, taken, setIntEn, nextPc and cycles are all zero.
- R2: An operation is accepted on a rising edge where opValid is 1. Its result appears on the outputs after that edge, and resValid is 1 for exactly that one cycle. When opValid is 0, resValid and setIntEn drop to 0 and nextPc, taken and cycles keep their values.
- R3: Opcode 1 (relative jump) gives nextPc = pcIn + sext(relLong) + 1, taken 1, 2 clocks. Opcode 2 (relative call) gives the same target, taken 1, 3 clocks.
- R4: All PC arithmetic wraps modulo 2^PCW. The 12-bit and 7-bit offsets are two's complement values.
- R5: Opcode 3 (indirect jump) gives nextPc = zPtr, taken 1, 2 clocks. Opcode 4 (indirect call) gives the same target with 3 clocks.
- R6: Opcode 5 (return) and opcode 6 (return from interrupt) give taken 1, 4 clocks and nextPc = pcIn, because the stack supplies the real target. Only opcode 6 raises setIntEn, and only for that one result cycle.
- R7: Opcode 7 branches when sreg[bitSel] is 1. Opcode 8 branches when sreg[bitSel] is 0. A taken branch gives pcIn + sext(relShort) + 1, taken 1, 2 clocks. A branch that is not taken gives pcIn + 1, taken 0, 1 clock.
- R8: Opcode 9 (signed greater-or-equal) branches when sreg[2] XOR sreg[3] is 0. Opcode 10 (signed less-than) branches when it is 1. Here N is bit 2 and V is bit 3. Timing and targets are as in R7.
- R9: When a skip condition is false, the result is pcIn + 1, taken 0, 1 clock. When it is true and nextWordTwo is 0, the result is pcIn + 2, taken 1, 2 clocks. When it is true and nextWordTwo is 1, the result is pcIn + 3, taken 1, 3 clocks.
- R10: The skip conditions are as follows. Opcode 11 skips when regVal equals cmpVal. Opcode 12 skips when regVal[bitSel] is 0, and opcode 13 when it is 1. Opcode 14 skips when ioByte[bitSel] is 0, and opcode 15 when it is 1.
- R11: Opcode 0 (not a control-flow operation) gives pcIn + 1, taken 0, 1 clock, and setIntEn 0.
- R12: nextWordTwo has no effect on any opcode other than 11 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Accept the operation this cycle |
| opCode | input | 4 | Classified control-flow operation (0 to 15) |
| pcIn | input | PCW | Address of the current instruction |
| relLong | input | 12 | Signed offset for relative jump and call |
| relShort | input | 7 | Signed offset for conditional branch |
| zPtr | input | 16 | Indirect target pointer |
| sreg | input | 8 | Status byte (C0 Z1 N2 V3 S4 H5 T6 I7) |
| bitSel | input | 3 | Bit index for branch and bit tests |
| regVal | input | 8 | First register operand / tested register |
| cmpVal | input | 8 | Second register operand for compare-skip |
| ioByte | input | 8 | Byte read from I/O locations 0x00 to 0x1F |
| nextWordTwo | input | 1 | The following instruction is two words long |
| resValid | output | 1 | Result present this cycle |
| nextPc | output | PCW | Next program counter |
| taken | output | 1 | Flow redirected or instruction skipped |
| cycles | output | 3 | Clocks the instruction occupies (1 to 4) |
| setIntEn | output | 1 | Set the global interrupt flag |

## Verification
On every cycle the assertions check the handshake timing of resValid. They also check that a result that is not taken is always a plain increment costing one clock, that the clock count stays in range, and that the interrupt-enable request occurs only with a four-clock taken return. Which status bit, register bit or I/O bit is selected, the sign extension and wrap-around of the offsets, and the choice between a one-word and a two-word skip can only be shown by the bench's directed scenarios, which compare exact target addresses.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

  typedef enum logic [3:0] {
    OP_NONE  = 4'd0,
    OP_JREL  = 4'd1,
    OP_CREL  = 4'd2,
    OP_JIND  = 4'd3,
    OP_CIND  = 4'd4,
    OP_RET   = 4'd5,
    OP_RETI  = 4'd6,
    OP_BSET  = 4'd7,
    OP_BCLR  = 4'd8,
    OP_BGE   = 4'd9,
    OP_BLT   = 4'd10,
    OP_SKEQ  = 4'd11,
    OP_SKRC  = 4'd12,
    OP_SKRS  = 4'd13,
    OP_SKIC  = 4'd14,
    OP_SKIS  = 4'd15
  } ctrlOp_e;

  typedef enum logic [2:0] {
    PC_INC1,
    PC_INC2,
    PC_INC3,
    PC_REL_LONG,
    PC_REL_SHORT,
    PC_ZPTR,
    PC_HOLD
  } pcSel_e;

  typedef struct packed {
    pcSel_e     pcSel;
    logic       taken;
    logic [2:0] cycles;
    logic       setIntEn;
  } ctrlStrobe_t;

  localparam int FLAG_N = 2;
  localparam int FLAG_V = 3;

endpackage

// File: rtl/bsu_ctrl.sv
module bsu_ctrl
  import bsu_pkg::*;
#(
  parameter int DW = 8,
  parameter int BW = 3
) (
  input  logic [3:0]    opCode,
  input  logic [DW-1:0] sreg,
  input  logic [BW-1:0] bitSel,
  input  logic [DW-1:0] regVal,
  input  logic [DW-1:0] cmpVal,
  input  logic [DW-1:0] ioByte,
  input  logic          nextWordTwo,
  output ctrlStrobe_t   strobe
);

  ctrlOp_e op;
  logic    isBranch;
  logic    isSkip;
  logic    cond;
  logic    signLess;

  assign op       = ctrlOp_e'(opCode);
  assign signLess = sreg[FLAG_N] ^ sreg[FLAG_V];

  // condition selection for branches and skips
  always_comb begin
    isBranch = 1'b0;
    isSkip   = 1'b0;
    cond     = 1'b0;
    unique case (op)
      OP_BSET: begin isBranch = 1'b1; cond = sreg[bitSel];    end
      OP_BCLR: begin isBranch = 1'b1; cond = !sreg[bitSel];   end
      OP_BGE:  begin isBranch = 1'b1; cond = !signLess;       end
      OP_BLT:  begin isBranch = 1'b1; cond = signLess;        end
      OP_SKEQ: begin isSkip = 1'b1;   cond = (regVal == cmpVal); end
      OP_SKRC: begin isSkip = 1'b1;   cond = !regVal[bitSel]; end
      OP_SKRS: begin isSkip = 1'b1;   cond = regVal[bitSel];  end
      OP_SKIC: begin isSkip = 1'b1;   cond = !ioByte[bitSel]; end
      OP_SKIS: begin isSkip = 1'b1;   cond = ioByte[bitSel];  end
      default: ;
    endcase
  end

  // strobe generation
  always_comb begin
    strobe = '{pcSel: PC_INC1, taken: 1'b0, cycles: 3'd1, setIntEn: 1'b0};
    if (isBranch) begin
      if (cond) strobe = '{pcSel: PC_REL_SHORT, taken: 1'b1, cycles: 3'd2, setIntEn: 1'b0};
    end else if (isSkip) begin
      if (cond) begin
        if (nextWordTwo) strobe = '{pcSel: PC_INC3, taken: 1'b1, cycles: 3'd3, setIntEn: 1'b0};
        else             strobe = '{pcSel: PC_INC2, taken: 1'b1, cycles: 3'd2, setIntEn: 1'b0};
      end
    end else begin
      unique case (op)
        OP_JREL: strobe = '{pcSel: PC_REL_LONG, taken: 1'b1, cycles: 3'd2, setIntEn: 1'b0};
        OP_CREL: strobe = '{pcSel: PC_REL_LONG, taken: 1'b1, cycles: 3'd3, setIntEn: 1'b0};
        OP_JIND: strobe = '{pcSel: PC_ZPTR,     taken: 1'b1, cycles: 3'd2, setIntEn: 1'b0};
        OP_CIND: strobe = '{pcSel: PC_ZPTR,     taken: 1'b1, cycles: 3'd3, setIntEn: 1'b0};
        OP_RET:  strobe = '{pcSel: PC_HOLD,     taken: 1'b1, cycles: 3'd4, setIntEn: 1'b0};
        OP_RETI: strobe = '{pcSel: PC_HOLD,     taken: 1'b1, cycles: 3'd4, setIntEn: 1'b1};
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/bsu_datapath.sv
module bsu_datapath
  import bsu_pkg::*;
#(
  parameter int PCW    = 16,
  parameter int LONGW  = 12,
  parameter int SHORTW = 7,
  parameter int ZW     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  ctrlStrobe_t       strobe,
  input  logic [PCW-1:0]    pcIn,
  input  logic [LONGW-1:0]  relLong,
  input  logic [SHORTW-1:0] relShort,
  input  logic [ZW-1:0]     zPtr,
  output logic              resValid,
  output logic [PCW-1:0]    nextPc,
  output logic              taken,
  output logic [2:0]        cycles,
  output logic              setIntEn
);

  localparam int LONG_PAD  = PCW - LONGW;
  localparam int SHORT_PAD = PCW - SHORTW;
  localparam logic [PCW-1:0] ONE   = PCW'(1);
  localparam logic [PCW-1:0] TWO   = PCW'(2);
  localparam logic [PCW-1:0] THREE = PCW'(3);

  logic [PCW-1:0] longExt;
  logic [PCW-1:0] shortExt;
  logic [PCW-1:0] pcStep;
  logic [PCW-1:0] pcTarget;

  assign longExt  = {{LONG_PAD{relLong[LONGW-1]}}, relLong};
  assign shortExt = {{SHORT_PAD{relShort[SHORTW-1]}}, relShort};
  assign pcStep   = pcIn + ONE;

  always_comb begin
    unique case (strobe.pcSel)
      PC_INC2:      pcTarget = pcIn + TWO;
      PC_INC3:      pcTarget = pcIn + THREE;
      PC_REL_LONG:  pcTarget = pcStep + longExt;
      PC_REL_SHORT: pcTarget = pcStep + shortExt;
      PC_ZPTR:      pcTarget = zPtr[PCW-1:0];
      PC_HOLD:      pcTarget = pcIn;
      default:      pcTarget = pcStep;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      nextPc   <= '0;
      taken    <= 1'b0;
      cycles   <= '0;
      setIntEn <= 1'b0;
    end else if (opValid) begin
      resValid <= 1'b1;
      nextPc   <= pcTarget;
      taken    <= strobe.taken;
      cycles   <= strobe.cycles;
      setIntEn <= strobe.setIntEn;
    end else begin
      resValid <= 1'b0;
      setIntEn <= 1'b0;
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> resValid);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> (!resValid && $stable(nextPc) && !setIntEn));

  p_untaken_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !strobe.taken) |=> (nextPc == $past(pcIn) + ONE && cycles == 3'd1));

  p_cycles_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (cycles >= 3'd1 && cycles <= 3'd4));

  p_inten_return_r6: assert property (@(posedge clk) disable iff (!rstN)
    setIntEn |-> (resValid && taken && cycles == 3'd4));

endmodule

// File: rtl/bsu_top.sv
module bsu_top
  import bsu_pkg::*;
#(
  parameter int PCW = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           opValid,
  input  logic [3:0]     opCode,
  input  logic [PCW-1:0] pcIn,
  input  logic [11:0]    relLong,
  input  logic [6:0]     relShort,
  input  logic [15:0]    zPtr,
  input  logic [7:0]     sreg,
  input  logic [2:0]     bitSel,
  input  logic [7:0]     regVal,
  input  logic [7:0]     cmpVal,
  input  logic [7:0]     ioByte,
  input  logic           nextWordTwo,
  output logic           resValid,
  output logic [PCW-1:0] nextPc,
  output logic           taken,
  output logic [2:0]     cycles,
  output logic           setIntEn
);

  ctrlStrobe_t strobe;

  bsu_ctrl #(.DW(8), .BW(3)) u_ctrl (
    .opCode      (opCode),
    .sreg        (sreg),
    .bitSel      (bitSel),
    .regVal      (regVal),
    .cmpVal      (cmpVal),
    .ioByte      (ioByte),
    .nextWordTwo (nextWordTwo),
    .strobe      (strobe)
  );

  bsu_datapath #(.PCW(PCW), .LONGW(12), .SHORTW(7), .ZW(16)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .opValid  (opValid),
    .strobe   (strobe),
    .pcIn     (pcIn),
    .relLong  (relLong),
    .relShort (relShort),
    .zPtr     (zPtr),
    .resValid (resValid),
    .nextPc   (nextPc),
    .taken    (taken),
    .cycles   (cycles),
    .setIntEn (setIntEn)
  );

endmodule

// File: tb/bsu_top_tb.sv
`timescale 1ns/1ps
module bsu_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  opCode = '0;
  logic [15:0] pcIn = '0;
  logic [11:0] relLong = '0;
  logic [6:0]  relShort = '0;
  logic [15:0] zPtr = '0;
  logic [7:0]  sreg = '0;
  logic [2:0]  bitSel = '0;
  logic [7:0]  regVal = '0;
  logic [7:0]  cmpVal = '0;
  logic [7:0]  ioByte = '0;
  logic        nextWordTwo = 1'b0;
  logic        resValid;
  logic [15:0] nextPc;
  logic        taken;
  logic [2:0]  cycles;
  logic        setIntEn;

  int nRun = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  bsu_top #(.PCW(16)) u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .pcIn(pcIn),
    .relLong(relLong), .relShort(relShort), .zPtr(zPtr), .sreg(sreg),
    .bitSel(bitSel), .regVal(regVal), .cmpVal(cmpVal), .ioByte(ioByte),
    .nextWordTwo(nextWordTwo), .resValid(resValid), .nextPc(nextPc),
    .taken(taken), .cycles(cycles), .setIntEn(setIntEn)
  );

  function automatic logic [15:0] sx12(input logic [11:0] v);
    return {{4{v[11]}}, v};
  endfunction
  function automatic logic [15:0] sx7(input logic [6:0] v);
    return {{9{v[6]}}, v};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  // apply one operation at a falling edge; return at the next falling edge
  task automatic issue(input logic [3:0] op, input logic [15:0] pc);
    opCode  = op;
    pcIn    = pc;
    opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic expectRes(input string tag, input logic [15:0] pc,
                           input logic tk, input logic [2:0] cy, input logic ie);
    chk({tag, " valid"}, resValid, 1'b1);
    chk({tag, " pc"}, nextPc, pc);
    chk({tag, " taken"}, taken, tk);
    chk({tag, " cycles"}, cycles, cy);
    chk({tag, " setIntEn"}, setIntEn, ie);
  endtask

  task automatic tReset();
    chk("R1 valid", resValid, 0); chk("R1 pc", nextPc, 0);
    chk("R1 taken", taken, 0); chk("R1 cycles", cycles, 0); chk("R1 ie", setIntEn, 0);
  endtask

  task automatic tRelative();
    relLong = 12'h07F; issue(4'd1, 16'h0100);
    expectRes("R3 jrel fwd", 16'h0100 + sx12(12'h07F) + 16'd1, 1, 3'd2, 0);
    relLong = 12'hF00; issue(4'd2, 16'h0400);
    expectRes("R3 crel back", 16'h0400 + sx12(12'hF00) + 16'd1, 1, 3'd3, 0);
  endtask

  task automatic tWrap();
    relLong = 12'h800; issue(4'd1, 16'h0010);
    expectRes("R4 wrap low", 16'h0010 + sx12(12'h800) + 16'd1, 1, 3'd2, 0);
    relShort = 7'h3F; issue(4'd7, 16'hFFF0);
    // sreg bit 0 set below in tWrap caller
    expectRes("R4 wrap high", 16'hFFF0 + sx7(7'h3F) + 16'd1, 1, 3'd2, 0);
  endtask

  task automatic tIndirect();
    zPtr = 16'hBEEF; issue(4'd3, 16'h0001);
    expectRes("R5 jind", 16'hBEEF, 1, 3'd2, 0);
    zPtr = 16'h1234; issue(4'd4, 16'h0002);
    expectRes("R5 cind", 16'h1234, 1, 3'd3, 0);
  endtask

  task automatic tReturn();
    issue(4'd5, 16'h0222);
    expectRes("R6 ret", 16'h0222, 1, 3'd4, 0);
    issue(4'd6, 16'h0333);
    expectRes("R6 reti", 16'h0333, 1, 3'd4, 1);
    @(negedge clk);
    chk("R6 ie one-shot", setIntEn, 0);
    chk("R2 valid drops", resValid, 0);
    chk("R2 pc holds", nextPc, 16'h0333);
  endtask

  task automatic tBranchBits();
    sreg = 8'b1010_0110; relShort = 7'h70;
    for (int b = 0; b < 8; b++) begin
      bitSel = 3'(b);
      issue(4'd7, 16'h0200);
      if (sreg[b]) expectRes("R7 bset", 16'h0200 + sx7(7'h70) + 16'd1, 1, 3'd2, 0);
      else         expectRes("R7 bset", 16'h0201, 0, 3'd1, 0);
      issue(4'd8, 16'h0300);
      if (!sreg[b]) expectRes("R7 bclr", 16'h0300 + sx7(7'h70) + 16'd1, 1, 3'd2, 0);
      else          expectRes("R7 bclr", 16'h0301, 0, 3'd1, 0);
    end
  endtask

  task automatic tSigned();
    relShort = 7'h05;
    for (int nv = 0; nv < 4; nv++) begin
      logic n, v;
      n = nv[0]; v = nv[1];
      sreg = 8'h00; sreg[2] = n; sreg[3] = v;
      issue(4'd9, 16'h0500);
      if (!(n ^ v)) expectRes("R8 bge", 16'h0506, 1, 3'd2, 0);
      else          expectRes("R8 bge", 16'h0501, 0, 3'd1, 0);
      issue(4'd10, 16'h0500);
      if (n ^ v) expectRes("R8 blt", 16'h0506, 1, 3'd2, 0);
      else       expectRes("R8 blt", 16'h0501, 0, 3'd1, 0);
    end
  endtask

  task automatic tSkips();
    regVal = 8'h5A; cmpVal = 8'h5A; nextWordTwo = 1'b0;
    issue(4'd11, 16'h0700); expectRes("R9 R10 skeq one", 16'h0702, 1, 3'd2, 0);
    nextWordTwo = 1'b1;
    issue(4'd11, 16'h0700); expectRes("R9 R10 skeq two", 16'h0703, 1, 3'd3, 0);
    cmpVal = 8'h5B;
    issue(4'd11, 16'h0700); expectRes("R9 R10 skeq false", 16'h0701, 0, 3'd1, 0);
    bitSel = 3'd0; nextWordTwo = 1'b0;
    issue(4'd12, 16'h0800); expectRes("R10 skrc", 16'h0802, 1, 3'd2, 0);
    issue(4'd13, 16'h0800); expectRes("R10 skrs", 16'h0801, 0, 3'd1, 0);
    ioByte = 8'h80; bitSel = 3'd7; nextWordTwo = 1'b1;
    issue(4'd15, 16'hFFFE); expectRes("R10 skis wrap", 16'h0001, 1, 3'd3, 0);
    issue(4'd14, 16'h0900); expectRes("R10 skic", 16'h0901, 0, 3'd1, 0);
  endtask

  task automatic tNoneAndIgnore();
    nextWordTwo = 1'b0;
    issue(4'd0, 16'h0A00); expectRes("R11 none", 16'h0A01, 0, 3'd1, 0);
    nextWordTwo = 1'b1;
    issue(4'd0, 16'h0A00); expectRes("R12 none two", 16'h0A01, 0, 3'd1, 0);
    relLong = 12'h010;
    issue(4'd1, 16'h0A00); expectRes("R12 jrel two", 16'h0A11, 1, 3'd2, 0);
    sreg = 8'h01; bitSel = 3'd0; relShort = 7'h02;
    issue(4'd7, 16'h0A00); expectRes("R12 bset two", 16'h0A03, 1, 3'd2, 0);
  endtask

  initial begin
    #(200000 * 10);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tRelative();
    sreg = 8'h01; bitSel = 3'd0;
    tWrap();
    tIndirect();
    tReturn();
    tBranchBits();
    tSigned();
    tSkips();
    tNoneAndIgnore();
    @(negedge clk);
    chk("R2 idle valid", resValid, 0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule